// File: doc/BRIEF.md
# Buck Stage PWM Output Controller

This block is the digital timing core of a current-mode buck stage that uses a synchronous rectifier. A free-running phase counter, clocked by a fast system clock, divides time into switching periods. At the start of each period an on-latch raises the main switch drive. The latch falls when the loop comparator reports that the sensed current has reached the control level, when the over-current comparator trips, when a soft-start ceiling is reached, or when the fixed maximum on-time runs out. The rectifier drive is the complement of the main drive, so the low-side switch conducts whenever the high-side switch is off.

The analog side stays outside. The loop comparator and the over-current comparator arrive as single-bit flags. The soft-start ramp arrives as a ceiling value, counted in clock cycles from the period start. A short window at the start of every period masks both comparator flags, so that the turn-on spike on the sense node cannot end a pulse. During that window a strobe output discharges the sense filter. Each period always ends with a guaranteed off stretch, which leaves time to recharge the bootstrap capacitor of the high-side driver. A fault or undervoltage input forces the switches into the safe state at once.

Top module: `buck_pwm_ctrl`

## Requirements
- R1: The phase counter runs 0 to PERIOD_CYC-1 and wraps. The main drive is high from phase 1 and, if nothing stops it earlier, stays high for exactly MAXON = PERIOD_CYC - MINOFF_CYC cycles (phases 1..MAXON).
- R2: `syncDrv` is always the inverse of `mainDrv`.
- R3: The main drive is low at phase 0 and at every phase above MAXON, which gives at least MINOFF_CYC off cycles in every period.
- R4: `blankStrobe` is high at phases 0..BLANK_CYC-1 and low at all other phases. A flag from either comparator at phases 1..BLANK_CYC-1 does not end the pulse.
- R5: If `pwmTrip` is high at a phase p with p >= BLANK_CYC while the drive is on, the drive is high through phase p and low from phase p+1.
- R6: A `limitTrip` at phase p >= BLANK_CYC ends only the present pulse, with the same timing as R5. The next period starts a normal pulse.
- R7: While `faultIn` is high, `mainDrv` is low and `syncDrv` is high in the same cycle. After `faultIn` falls, no pulse restarts before the next period start.
- R8: If `pwmTrip` is high at phase 0, that period has no on-pulse.
- R9: `ssCeil` = c limits the on-time to min(c, MAXON) cycles (phases 1..c). A value of c = 0 gives zero duty.
- R10: Once the drive has fallen within a period, it stays low until the next period start, even if every flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count of the phase counter per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| faultIn | input | 1 | Fault or undervoltage-off indication; forces the safe state |
| pwmTrip | input | 1 | Loop comparator flag: sensed current has reached the control level |
| limitTrip | input | 1 | Over-current comparator flag |
| ssCeil | input | CW | Soft-start on-time ceiling in clock cycles, CW = clog2(PERIOD_CYC+1) |
| mainDrv | output | 1 | High-side (main) switch drive |
| syncDrv | output | 1 | Synchronous rectifier drive, the inverse of mainDrv |
| blankStrobe | output | 1 | Blanking window; high during the first BLANK_CYC phases to discharge the sense node |

## Verification
There are two likely internal faults. A latch that sets again after a trip, or fails to clear, shows as a second rising edge of `mainDrv` in the same period. It can also show as a high drive in the reserved off stretch, and the per-cycle scoreboard catches either one on the very next cycle. A phase counter that is off by one moves the pulse edges and the `blankStrobe` window by one cycle against the independent phase model in the bench. The bench detects this within the first period after reset. Trips placed just inside and just outside the blanking window, a flag held high at phase 0, a zero ceiling and a fault that drops in the middle of a pulse each pin one cycle boundary.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;

  // Phase decodes passed from the timing datapath to the latch control
  typedef struct packed {
    logic atStart;   // phase counter at 0
    logic inBlank;   // phase inside the comparator blanking window
    logic atMaxOn;   // phase has reached the maximum on-time
    logic atCeil;    // phase has reached the soft-start ceiling
  } phaseStrb_t;

endpackage

// File: rtl/buck_pwm_timer.sv
module buck_pwm_timer
  import buck_pwm_pkg::*;
#(
  parameter int PERIOD_CYC = 50,
  parameter int BLANK_CYC  = 3,
  parameter int MAXON_CYC  = 38,
  parameter int PW         = $clog2(PERIOD_CYC),
  parameter int CW         = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] ssCeil,
  output phaseStrb_t    strb,
  output logic [PW-1:0] phaseCnt
);

  localparam logic [PW-1:0] LastPhase = PW'(PERIOD_CYC - 1);
  localparam logic [PW-1:0] MaxOnPhase = PW'(MAXON_CYC);

  always_ff @(posedge clk) begin
    if (!rstN)                   phaseCnt <= '0;
    else if (phaseCnt == LastPhase) phaseCnt <= '0;
    else                         phaseCnt <= phaseCnt + 1'b1;
  end

  logic blankWin;
  generate
    if (BLANK_CYC == 0) begin : g_noBlank
      assign blankWin = 1'b0;
    end else begin : g_blank
      assign blankWin = (phaseCnt < PW'(BLANK_CYC));
    end
  endgenerate

  always_comb begin
    strb.atStart = (phaseCnt == '0);
    strb.inBlank = blankWin;
    strb.atMaxOn = (phaseCnt >= MaxOnPhase);
    strb.atCeil  = (CW'(phaseCnt) >= ssCeil);
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= LastPhase);

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseCnt == LastPhase) |=> (phaseCnt == '0));

endmodule

// File: rtl/buck_pwm_latch.sv
module buck_pwm_latch
  import buck_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultIn,
  input  logic       pwmTrip,
  input  logic       limitTrip,
  input  phaseStrb_t strb,
  output logic       driveOn
);

  logic onD;
  logic senseTrip;

  // Comparator flags count only outside the blanking window
  assign senseTrip = !strb.inBlank && (pwmTrip || limitTrip);

  always_comb begin
    onD = 1'b0;
    if (faultIn)
      onD = 1'b0;
    else if (strb.atStart)
      onD = !pwmTrip && !strb.atCeil;
    else if (driveOn)
      onD = !(strb.atMaxOn || strb.atCeil || senseTrip);
  end

  always_ff @(posedge clk) begin
    if (!rstN) driveOn <= 1'b0;
    else       driveOn <= onD;
  end

  // R4
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveOn && strb.inBlank && !strb.atStart && !strb.atMaxOn &&
     !strb.atCeil && !faultIn) |=> driveOn);

  // R10
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!driveOn && !strb.atStart) |=> !driveOn);

  // R7
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> !driveOn);

endmodule

// File: rtl/buck_pwm_ctrl.sv
module buck_pwm_ctrl
  import buck_pwm_pkg::*;
#(
  parameter int  PERIOD_CYC = 50,
  parameter int  BLANK_CYC  = 3,
  parameter int  MINOFF_CYC = 12,
  localparam int CW         = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          faultIn,
  input  logic          pwmTrip,
  input  logic          limitTrip,
  input  logic [CW-1:0] ssCeil,
  output logic          mainDrv,
  output logic          syncDrv,
  output logic          blankStrobe
);

  localparam int PW        = $clog2(PERIOD_CYC);
  localparam int MAXON_CYC = PERIOD_CYC - MINOFF_CYC;

  phaseStrb_t    strb;
  logic [PW-1:0] phaseCnt;
  logic          driveOn;

  buck_pwm_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .MAXON_CYC (MAXON_CYC),
    .PW        (PW),
    .CW        (CW)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .ssCeil  (ssCeil),
    .strb    (strb),
    .phaseCnt(phaseCnt)
  );

  buck_pwm_latch u_latch (
    .clk      (clk),
    .rstN     (rstN),
    .faultIn  (faultIn),
    .pwmTrip  (pwmTrip),
    .limitTrip(limitTrip),
    .strb     (strb),
    .driveOn  (driveOn)
  );

  assign mainDrv     = driveOn && !faultIn;
  assign syncDrv     = !mainDrv;
  assign blankStrobe = strb.inBlank;

  // R3
  min_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phaseCnt > PW'(MAXON_CYC)) || (phaseCnt == '0)) |-> !mainDrv);

  // R9
  ceil_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.atCeil |=> !mainDrv);

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.atStart && pwmTrip) |=> !mainDrv);

endmodule

// File: tb/sim_buck_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_buck_pwm_ctrl;

  localparam int PER   = 50;
  localparam int BL    = 3;
  localparam int MOFF  = 12;
  localparam int MAXON = PER - MOFF;
  localparam int CW    = $clog2(PER + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultIn = 1'b0, pwmTrip = 1'b0, limitTrip = 1'b0;
  logic [CW-1:0] ssCeil = '1;
  logic mainDrv, syncDrv, blankStrobe;

  always #10 clk = ~clk;

  buck_pwm_ctrl #(.PERIOD_CYC(PER), .BLANK_CYC(BL), .MINOFF_CYC(MOFF)) u0 (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .pwmTrip(pwmTrip),
    .limitTrip(limitTrip), .ssCeil(ssCeil), .mainDrv(mainDrv),
    .syncDrv(syncDrv), .blankStrobe(blankStrobe)
  );

  typedef struct {
    logic  expMain;
    logic  expBlank;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];
  int vecs = 0;
  int miss = 0;
  int mPhase = 0;
  logic mOn = 1'b0;

  task automatic checkBit(string tag, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compare each expected item against the ports mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        checkBit(it.tag, mainDrv, it.expMain);
        checkBit("R2", syncDrv, !it.expMain);
        checkBit("R4", blankStrobe, it.expBlank);
      end
    end
  end

  // Driver: one full period, flags high over [at, at+len)
  task automatic runPeriod(string tag, int pwmAt, int pwmLen, int limAt,
                           int limLen, int fltAt, int fltLen, int ceil);
    for (int k = 0; k < PER; k++) begin
      logic p, l, f;
      expItem_t it;
      p = (pwmAt >= 0) && (mPhase >= pwmAt) && (mPhase < pwmAt + pwmLen);
      l = (limAt >= 0) && (mPhase >= limAt) && (mPhase < limAt + limLen);
      f = (fltAt >= 0) && (mPhase >= fltAt) && (mPhase < fltAt + fltLen);
      pwmTrip = p; limitTrip = l; faultIn = f; ssCeil = CW'(ceil);
      it.expMain  = mOn && !f;
      it.expBlank = (mPhase < BL);
      it.tag      = tag;
      sbQ.push_back(it);
      if (f)
        mOn = 1'b0;
      else if (mPhase == 0)
        mOn = !p && (ceil > 0);
      else if (mOn)
        mOn = !((mPhase >= BL) && (p || l)) && (mPhase < MAXON) && (mPhase < ceil);
      mPhase = (mPhase == PER - 1) ? 0 : mPhase + 1;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checkBit("R7", mainDrv, 1'b0);
    checkBit("R2", syncDrv, 1'b1);
    checkBit("R4", blankStrobe, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    runPeriod("R1", -1, 0, -1, 0, -1, 0, 63);      // full MAXON pulse
    runPeriod("R3", -1, 0, -1, 0, -1, 0, MAXON);   // ceiling equal to MAXON
    runPeriod("R9", -1, 0, -1, 0, -1, 0, 10);      // soft-start limit
    runPeriod("R9", -1, 0, -1, 0, -1, 0, MAXON - 1);
    runPeriod("R5", 20, 30, -1, 0, -1, 0, 63);     // loop trip at 20
    runPeriod("R5", BL, 1, -1, 0, -1, 0, 63);      // trip at first unblanked phase
    runPeriod("R4", 1, BL - 1, 1, BL - 1, -1, 0, 63); // trips inside blanking
    runPeriod("R6", -1, 0, 25, 25, -1, 0, 63);     // current limit at 25
    runPeriod("R6", -1, 0, -1, 0, -1, 0, 63);      // next period normal
    runPeriod("R8", 0, PER, -1, 0, -1, 0, 63);     // flag high at start
    runPeriod("R9", -1, 0, -1, 0, -1, 0, 0);       // zero ceiling
    runPeriod("R7", -1, 0, -1, 0, 10, 5, 63);      // fault mid-pulse
    runPeriod("R7", -1, 0, -1, 0, -1, 0, 63);      // recovery
    runPeriod("R10", 20, 3, -1, 0, -1, 0, 63);     // flag clears, no restart
    runPeriod("R10", -1, 0, 5, 2, -1, 0, 30);
    @(negedge clk);
    #4;
    finishRun();
  end

endmodule